// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Timer

This block drives three complementary output pairs (high side and low side for phases 0, 1 and 2) from one shared period timebase. Each period has two halves of programmable length. In every half, the high-side pulse sits against the centre of the period and the low-side pulse sits against the period boundary, so each pulse is symmetric about the period centre. A dead-time value and a signed per-phase duty value set how far each pulse edge moves from the half-way point of its half. A one-cycle sync strobe marks each period start, and a status bit shows which half is running.

All programming goes through a single write port into shadow registers. The running values are copied from the shadows only at fixed reload points. In single update mode that is once per period. In double update mode it also happens at the mid-period point, so the second half can use a new length, dead time or duty. The first write of the half-period register starts the timebase. The outputs stay low until the half-period register and all three duty registers have each been written at least once.

Top module: `pwm3_ctr`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, all six PWM outputs, `sync_pulse` and `half_status` are 0.
- R2: Register addresses on `wr_addr`: 0 half-period P (unsigned), 1 dead time T (unsigned), 2/3/4 duty D of phase 0/1/2 (two's complement, signed), 5 mode (bit 0: 0 single update, 1 double update). Writes go to shadow copies. In single update mode, a write made during a period does not change any output before the next period start.
- R3: A period is made of a first half of P cycles followed by a second half of P cycles, where each half uses the P that is active in it. `half_status` is 0 in the first half and 1 in the second half. `sync_pulse` is 1 only in the first cycle of each period. P must be at least 2.
- R4: Let c be the cycle index within a half (0 to P-1). Let TH = P − 2(D+T) and TL = P + 2(D−T), each clamped as in R5. In the first half, low is active for c < floor(TL/2) and high is active for c ≥ P − ceil(TH/2). In the second half, high is active for c < floor(TH/2) and low is active for c ≥ P − ceil(TL/2).
- R5: TH and TL are clamped to the range 0 to 2P. A pulse width of 0 keeps the output low for the whole half. A width of 2P keeps it high for the whole half.
- R6: Dead time T shortens both the high and the low pulse by T cycles at every edge inside each half, with the rest of R4 unchanged.
- R7: The outputs stay low until P and all three duty registers have each been written at least once. Enabling takes effect at the first period start after the last of those writes.
- R8: The first write of P after reset starts the timebase. The first `sync_pulse` appears 3P cycles after that write when mode bit 0 was 0, and P cycles after it when mode bit 0 was 1.
- R9: In double update mode, the shadow values are also loaded at the mid-period point. The second half then uses any new P, T and D values, and its length follows the new P.
- R10: A change of the mode bit takes effect at the next period start. Until then, the mid-period reload follows the previous mode.
- R11: A write taken in the same clock edge as a reload is not seen by that reload. It takes effect at the following reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (see R2) |
| wr_data | input | CW | Write data |
| pwm_h | output | 3 | High-side outputs, bit n = phase n |
| pwm_l | output | 3 | Low-side outputs, bit n = phase n |
| sync_pulse | output | 1 | One-cycle period start strobe |
| half_status | output | 1 | 0 in the first half, 1 in the second half |

## Verification
The two functions that can fall in the same cycle are a register write and a reload of the running values, at either the period start or the mid-period point. The bench provokes this by placing a duty write on the last sample of a first half in double update mode, so that the write is captured at the same edge as the mid-period reload. It then judges that the second half still shows the old pulse placement and that the new value appears only from the next period start. Mode changes and duty writes placed inside a period are judged the same way, by comparing every output in every cycle against the placement rule.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

    localparam int NPH = 3;
    localparam int AW  = 3;

    typedef enum logic [AW-1:0] {
        A_HALF  = 3'd0,
        A_DEAD  = 3'd1,
        A_DUTY0 = 3'd2,
        A_DUTY1 = 3'd3,
        A_DUTY2 = 3'd4,
        A_MODE  = 3'd5
    } reg_addr_e;

    typedef enum logic {
        UPD_SINGLE = 1'b0,
        UPD_DOUBLE = 1'b1
    } upd_mode_e;

    typedef enum logic {
        HALF_FIRST  = 1'b0,
        HALF_SECOND = 1'b1
    } half_e;

    typedef enum logic [1:0] {
        TB_IDLE,
        TB_WARM,
        TB_RUN
    } tb_state_e;

endpackage

// File: rtl/pwm3_regs.sv
module pwm3_regs
    import pwm3_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [CW-1:0]           wr_data,
    output logic [CW-1:0]           sh_period,
    output logic [CW-1:0]           sh_dead,
    output logic [NPH-1:0][CW-1:0]  sh_duty,
    output logic                    sh_mode,
    output logic                    armed,
    output logic                    p_wr
);

    logic [NPH:0] seen;

    assign p_wr  = wr_en && (wr_addr == A_HALF);
    assign armed = &seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_period <= '0;
            sh_dead   <= '0;
            sh_duty   <= '0;
            sh_mode   <= 1'b0;
            seen      <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                A_HALF: begin
                    sh_period <= wr_data;
                    seen[NPH] <= 1'b1;
                end
                A_DEAD:  sh_dead <= wr_data;
                A_DUTY0: begin
                    sh_duty[0] <= wr_data;
                    seen[0]    <= 1'b1;
                end
                A_DUTY1: begin
                    sh_duty[1] <= wr_data;
                    seen[1]    <= 1'b1;
                end
                A_DUTY2: begin
                    sh_duty[2] <= wr_data;
                    seen[2]    <= 1'b1;
                end
                A_MODE:  sh_mode <= wr_data[0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pwm3_timebase.sv
module pwm3_timebase
    import pwm3_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          p_wr,
    input  logic [CW-1:0] p_wdata,
    input  logic [CW-1:0] sh_period,
    input  logic          sh_mode,
    input  logic          armed,
    output logic [CW-1:0] cnt,
    output half_e         half,
    output logic [CW-1:0] p_act,
    output logic          en_act,
    output logic          sync_o,
    output logic          load_o
);

    localparam int WW = CW + 2;

    tb_state_e  st;
    upd_mode_e  mode_act;
    logic [WW-1:0] warm;
    logic [WW-1:0] delay;
    logic       end_half;
    logic       start_evt;
    logic       mid_evt;

    // startup wait: P cycles in double mode, 3P in single mode
    assign delay     = sh_mode ? WW'(p_wdata) : (WW'(p_wdata) + (WW'(p_wdata) << 1));
    assign end_half  = (cnt == p_act - CW'(1));
    assign start_evt = ((st == TB_WARM) && (warm == '0)) ||
                       ((st == TB_RUN) && (half == HALF_SECOND) && end_half);
    assign mid_evt   = (st == TB_RUN) && (half == HALF_FIRST) && end_half;
    assign load_o    = start_evt || (mid_evt && (mode_act == UPD_DOUBLE));

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= TB_IDLE;
            warm     <= '0;
            cnt      <= '0;
            half     <= HALF_FIRST;
            p_act    <= '0;
            mode_act <= UPD_SINGLE;
            en_act   <= 1'b0;
            sync_o   <= 1'b0;
        end else begin
            sync_o <= start_evt;
            case (st)
                TB_IDLE: begin
                    if (p_wr) begin
                        st   <= TB_WARM;
                        warm <= delay - WW'(1);
                    end
                end
                TB_WARM: begin
                    if (warm == '0) st <= TB_RUN;
                    else            warm <= warm - WW'(1);
                end
                default: ;
            endcase

            if (start_evt) begin
                cnt      <= '0;
                half     <= HALF_FIRST;
                mode_act <= upd_mode_e'(sh_mode);
                en_act   <= armed;
            end else if (mid_evt) begin
                cnt  <= '0;
                half <= HALF_SECOND;
            end else if (st == TB_RUN) begin
                cnt <= cnt + CW'(1);
            end

            if (load_o) p_act <= sh_period;
        end
    end

endmodule

// File: rtl/pwm3_phase.sv
module pwm3_phase
    import pwm3_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] sh_period,
    input  logic [CW-1:0] sh_dead,
    input  logic [CW-1:0] sh_duty,
    input  logic [CW-1:0] cnt,
    input  half_e         half,
    input  logic [CW-1:0] p_act,
    input  logic          en,
    output logic          pwm_h,
    output logic          pwm_l
);

    localparam int TW = CW + 1;
    localparam int XW = CW + 4;

    logic signed [XW-1:0] p_s, d_s, t_s, two_p, hi_raw, lo_raw;
    logic [TW-1:0] th, tl;
    logic [TW-1:0] th_c, th_f, tl_c, tl_f, p_w, c_w;

    function automatic logic [TW-1:0] clamp_w(input logic signed [XW-1:0] v,
                                              input logic signed [XW-1:0] hi);
        if (v < 0)       return '0;
        else if (v > hi) return hi[TW-1:0];
        else             return v[TW-1:0];
    endfunction

    assign p_s    = $signed({4'b0000, sh_period});
    assign t_s    = $signed({4'b0000, sh_dead});
    assign d_s    = $signed({{4{sh_duty[CW-1]}}, sh_duty});
    assign two_p  = p_s <<< 1;
    assign hi_raw = p_s - ((d_s + t_s) <<< 1);
    assign lo_raw = p_s + ((d_s - t_s) <<< 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            th <= '0;
            tl <= '0;
        end else if (load) begin
            th <= clamp_w(hi_raw, two_p);
            tl <= clamp_w(lo_raw, two_p);
        end
    end

    assign th_f = th >> 1;
    assign th_c = (th + TW'(1)) >> 1;
    assign tl_f = tl >> 1;
    assign tl_c = (tl + TW'(1)) >> 1;
    assign p_w  = TW'(p_act);
    assign c_w  = TW'(cnt);

    always_comb begin
        if (!en) begin
            pwm_h = 1'b0;
            pwm_l = 1'b0;
        end else if (half == HALF_FIRST) begin
            pwm_l = c_w < tl_f;
            pwm_h = c_w >= (p_w - th_c);
        end else begin
            pwm_h = c_w < th_f;
            pwm_l = c_w >= (p_w - tl_c);
        end
    end

endmodule

// File: rtl/pwm3_ctr.sv
module pwm3_ctr
    import pwm3_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [CW-1:0]  wr_data,
    output logic [NPH-1:0] pwm_h,
    output logic [NPH-1:0] pwm_l,
    output logic           sync_pulse,
    output logic           half_status
);

    logic [CW-1:0]          sh_period, sh_dead, cnt, p_act;
    logic [NPH-1:0][CW-1:0] sh_duty;
    logic                   sh_mode, armed, p_wr, en_act, load;
    half_e                  half;

    pwm3_regs #(.CW(CW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sh_period (sh_period),
        .sh_dead   (sh_dead),
        .sh_duty   (sh_duty),
        .sh_mode   (sh_mode),
        .armed     (armed),
        .p_wr      (p_wr)
    );

    pwm3_timebase #(.CW(CW)) u_tb (
        .clk       (clk),
        .rst       (rst),
        .p_wr      (p_wr),
        .p_wdata   (wr_data),
        .sh_period (sh_period),
        .sh_mode   (sh_mode),
        .armed     (armed),
        .cnt       (cnt),
        .half      (half),
        .p_act     (p_act),
        .en_act    (en_act),
        .sync_o    (sync_pulse),
        .load_o    (load)
    );

    generate
        for (genvar g = 0; g < NPH; g++) begin : g_ph
            pwm3_phase #(.CW(CW)) u_ph (
                .clk       (clk),
                .rst       (rst),
                .load      (load),
                .sh_period (sh_period),
                .sh_dead   (sh_dead),
                .sh_duty   (sh_duty[g]),
                .cnt       (cnt),
                .half      (half),
                .p_act     (p_act),
                .en        (en_act),
                .pwm_h     (pwm_h[g]),
                .pwm_l     (pwm_l[g])
            );
        end
    endgenerate

    assign half_status = (half == HALF_SECOND);

endmodule

// File: rtl/pwm3_ctr_chk.sv
module pwm3_ctr_chk
    import pwm3_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic [NPH-1:0] pwm_h,
    input logic [NPH-1:0] pwm_l,
    input logic           sync_pulse,
    input logic           half_status
);

    logic rst_q = 1'b0;
    logic seen_sync = 1'b0;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst)             seen_sync <= 1'b0;
        else if (sync_pulse) seen_sync <= 1'b1;
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst_q |-> (pwm_h == '0 && pwm_l == '0 && !sync_pulse && !half_status));

    a_r3_sync_one_cycle: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |=> !sync_pulse);

    a_r3_sync_in_first_half: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |-> !half_status);

    a_r3_mid_not_sync: assert property (@(posedge clk) disable iff (rst)
        $rose(half_status) |-> !sync_pulse);

    a_r4_no_overlap: assert property (@(posedge clk) disable iff (rst)
        (pwm_h & pwm_l) == '0);

    a_r7_silent_before_start: assert property (@(posedge clk) disable iff (rst)
        !seen_sync |-> (pwm_h == '0 && pwm_l == '0));

endmodule

bind pwm3_ctr pwm3_ctr_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pwm_h       (pwm_h),
    .pwm_l       (pwm_l),
    .sync_pulse  (sync_pulse),
    .half_status (half_status)
);

// File: tb/pwm3_ctr_tb.sv
module pwm3_ctr_tb;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [2:0]    pwm_h, pwm_l;
    logic          sync_pulse, half_status;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // expectation per half (index 0 first half, 1 second half)
    int ep[2];
    int edt[2];
    int ed[2][3];
    bit een;
    // write schedule used inside a period
    int nw;
    int wk[4];
    int wa[4];
    int wd[4];

    always #4 clk = ~clk;  // 125 MHz

    pwm3_ctr #(.CW(CW)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .pwm_h       (pwm_h),
        .pwm_l       (pwm_l),
        .sync_pulse  (sync_pulse),
        .half_status (half_status)
    );

    function automatic int clampi(int v, int hi);
        if (v < 0) return 0;
        if (v > hi) return hi;
        return v;
    endfunction

    // returns {high, low} for one phase per the R4/R5/R6 placement rule
    function automatic logic [1:0] model(int hf, int c, int p, int d, int t);
        int th, tl;
        logic h, l;
        th = clampi(p - 2 * (d + t), 2 * p);
        tl = clampi(p + 2 * (d - t), 2 * p);
        if (hf == 0) begin
            l = c < (tl / 2);
            h = c >= (p - (th + 1) / 2);
        end else begin
            h = c < (th / 2);
            l = c >= (p - (tl + 1) / 2);
        end
        return {h, l};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(int a, int d);
        wr_en   = 1'b1;
        wr_addr = a[2:0];
        wr_data = d[CW-1:0];
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic do_reset();
        rst   = 1'b1;
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 during reset", {24'd0, sync_pulse, half_status, pwm_h, pwm_l}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", {24'd0, sync_pulse, half_status, pwm_h, pwm_l}, 32'd0);
    endtask

    // measures cycles from the first P write to the first sync (R8),
    // checking that outputs stay low meanwhile (R7)
    task automatic startup(string tag, int p, int exp_delay);
        int n = 0;
        bit quiet = 1'b1;
        wr(0, p);
        while (!sync_pulse && n < 1000) begin
            if (pwm_h != 0 || pwm_l != 0) quiet = 1'b0;
            @(negedge clk);
            n++;
        end
        check({tag, " R8 startup delay"}, n, exp_delay);
        check({tag, " R7 quiet before start"}, {31'd0, quiet}, 32'd1);
    endtask

    // one full period from the sync sample: every cycle checks sync and
    // status (R3) and the six outputs against the placement rule (R4)
    task automatic check_period(string tag);
        int tot = ep[0] + ep[1];
        for (int i = 0; i < tot; i++) begin
            int hf = (i < ep[0]) ? 0 : 1;
            int c  = (hf == 1) ? i - ep[0] : i;
            logic [2:0] eh, el;
            for (int g = 0; g < 3; g++) begin
                logic [1:0] m;
                m = model(hf, c, ep[hf], ed[hf][g], edt[hf]);
                eh[g] = een & m[1];
                el[g] = een & m[0];
            end
            check(tag, {24'd0, sync_pulse, half_status, pwm_h, pwm_l},
                  {24'd0, (i == 0), (hf == 1), eh, el});
            wr_en = 1'b0;
            for (int w = 0; w < nw; w++) begin
                if (wk[w] == i) begin
                    wr_en   = 1'b1;
                    wr_addr = wa[w][2:0];
                    wr_data = wd[w][CW-1:0];
                end
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
        nw    = 0;
    endtask

    task automatic set_both(int p, int t, int d0, int d1, int d2);
        for (int h = 0; h < 2; h++) begin
            ep[h] = p; edt[h] = t;
            ed[h][0] = d0; ed[h][1] = d1; ed[h][2] = d2;
        end
    endtask

    task automatic sched(int k, int a, int d);
        wk[nw] = k; wa[nw] = a; wd[nw] = d;
        nw++;
    endtask

    task automatic t_single_start();
        do_reset();
        startup("single", 10, 30);
        // not armed yet: writes complete arming during this period (R7)
        een = 1'b0;
        set_both(10, 0, 0, 0, 0);
        sched(1, 1, 1); sched(3, 2, 0); sched(5, 3, 2); sched(7, 4, -3);
        check_period("R7 silent while arming");
    endtask

    task automatic t_single_hold();
        een = 1'b1;
        set_both(10, 1, 0, 2, -3);
        sched(4, 2, 3);
        check_period("R2 single mode holds mid-period write");
    endtask

    task automatic t_mode_change();
        set_both(10, 1, 3, 2, -3);
        sched(1, 5, 1); sched(3, 3, 5);
        check_period("R10 mode change waits for period start");
    endtask

    task automatic t_double_duty();
        set_both(10, 1, 3, 5, -3);
        ed[1][1] = -2;
        sched(2, 3, -2);
        check_period("R9 double mode duty reload");
    endtask

    task automatic t_double_period();
        set_both(10, 1, 3, -2, -3);
        ep[1] = 7;
        sched(1, 0, 7);
        check_period("R9 double mode half length reload");
    endtask

    task automatic t_coincide();
        set_both(7, 1, 3, -2, -3);
        // write captured on the mid-period reload edge
        sched(6, 4, 1);
        check_period("R11 write on reload edge deferred");
    endtask

    task automatic t_clamp();
        set_both(7, 1, 3, -2, 1);
        ed[1][0] = 20; ed[1][1] = -20;
        sched(0, 2, 20); sched(1, 3, -20);
        check_period("R5 clamp to 0 and full half");
    endtask

    task automatic t_dead();
        set_both(7, 1, 20, -20, 1);
        edt[1] = 0;
        sched(0, 1, 0);
        check_period("R6 dead time change");
    endtask

    task automatic t_double_start();
        do_reset();
        wr(5, 1);
        startup("double", 8, 8);
    endtask

    initial begin
        nw = 0;
        een = 1'b0;
        @(negedge clk);
        t_single_start();
        t_single_hold();
        t_mode_change();
        t_double_duty();
        t_double_period();
        t_coincide();
        t_clamp();
        t_dead();
        t_double_start();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule